// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic stage for an 8-bit accumulator datapath. Each cycle it takes an operation code, a second operand (a register value or an immediate; the block does not care which), the present accumulator value and the present flag byte. It computes the new accumulator value and the new flag byte for that operation. The operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR, compare, increment, decrement, complement accumulator, complement carry, set carry, and four rotates.

Five flags are kept: sign, zero, auxiliary carry (nibble carry), even parity and carry. They are packed into one byte with fixed filler bits. By default the results are registered, so a result appears one clock after its inputs. A parameter instead selects a purely combinational path for datapaths that register the accumulator themselves. The surrounding sequencer holds the accumulator and flag registers and feeds them back in.

Top module: `acc_alu`

## Requirements
- R1: While reset is active, and after reset until the first clock, acc_out is 00h and flags_out is 02h. With the default registered build, acc_out and flags_out on each clock edge take the result of the inputs present at that edge.
- R2: Operation codes 0 (add) and 1 (add with carry) write (acc_in + operand + c) mod 256 to the accumulator and set CY to the carry out of bit 7. Here c is 0 for code 0 and flags_in CY for code 1. Adding 99h to 88h with CY clear gives 21h with flags 17h.
- R3: Operation codes 2 (subtract) and 3 (subtract with borrow) write (acc_in - operand - c) in two's complement to the accumulator. Here c is 0 for code 2 and flags_in CY for code 3. CY is set exactly when operand + c is greater than acc_in as unsigned values.
- R4: For add-type operations (codes 0, 1 and 8), AC is the carry out of bit 3 into bit 4. For subtract-type operations (codes 2, 3, 7 and 9), AC is set when the low nibble of acc_in is smaller than the low nibble of the subtrahend plus c.
- R5: For codes 0 to 9, S equals result bit 7, Z is set when the result is 00h, and P is set when the result has an even number of ones. For compare, the result is the difference.
- R6: Codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result and clear both CY and AC.
- R7: Code 7 (compare) sets the flags exactly as subtract would and leaves the accumulator equal to acc_in.
- R8: Codes 8 (increment) and 9 (decrement) change the accumulator by one modulo 256. They update S, Z, AC and P, and keep CY from flags_in.
- R9: Code 10 inverts all accumulator bits and leaves the flags unchanged. Code 11 inverts CY and code 12 sets CY. Codes 11 and 12 leave the accumulator and the other flags unchanged.
- R10: Code 15 rotates left through carry: the new CY is A7 and the new A0 is the old CY. Code 16 rotates right through carry: the new CY is A0 and the new A7 is the old CY. Only CY changes among the flags.
- R11: Code 13 rotates left, with A7 going to both A0 and CY. Code 14 rotates right, with A0 going to both A7 and CY. Only CY changes among the flags.
- R12: The flag byte holds, from bit 7 to bit 0: S, Z, 0, AC, 0, P, 1, CY. Bits 5 and 3 always read 0 and bit 1 always reads 1, whatever flags_in holds. Codes 17 to 31 pass acc_in through and pass the flags through with the filler bits forced to these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 5 | Operation select, encodings as in the requirements |
| operand | input | 8 | Second operand, register or immediate value |
| acc_in | input | 8 | Present accumulator value |
| flags_in | input | 8 | Present flag byte |
| acc_out | output | 8 | New accumulator value |
| flags_out | output | 8 | New flag byte |

## Verification
The block keeps no state apart from the output register, so any wrong decode, carry chain or flag rule shows on acc_out or flags_out one clock after the stimulus. Nothing is hidden for later. The boundary operands 00h, FFh, 0Fh, 7Fh, 80h and 01h hit the nibble carry, the borrow and the rotate edge bits. Each is applied under both an all-clear and an all-set incoming flag byte, so that any leak of the carry-in or of a passed-through flag appears at once. Random vectors that include the undefined codes are compared against a behavioural model on every clock.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W   = 5;
   localparam int FLAG_W = 8;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 5'd0,
      OP_ADC = 5'd1,
      OP_SUB = 5'd2,
      OP_SBB = 5'd3,
      OP_AND = 5'd4,
      OP_XOR = 5'd5,
      OP_OR  = 5'd6,
      OP_CMP = 5'd7,
      OP_INC = 5'd8,
      OP_DEC = 5'd9,
      OP_CMA = 5'd10,
      OP_CMC = 5'd11,
      OP_STC = 5'd12,
      OP_RLC = 5'd13,
      OP_RRC = 5'd14,
      OP_RAL = 5'd15,
      OP_RAR = 5'd16
   } alu_op_e;

   localparam int FB_S  = 7;
   localparam int FB_Z  = 6;
   localparam int FB_AC = 4;
   localparam int FB_P  = 2;
   localparam int FB_CY = 0;

   localparam logic [FLAG_W-1:0] FLAG_RESET = 8'h02;

   function automatic logic [FLAG_W-1:0] pack_flags(input logic s, input logic z,
                                                    input logic ac, input logic p,
                                                    input logic cy);
      return {s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
   endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout,
   output logic              half
);
   localparam int NIB = DATA_W / 2;

   logic [DATA_W:0] wide;
   logic [NIB:0]    low;

   always_comb begin
      if (sub) begin
         wide = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
         low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
      end else begin
         wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
         low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
      end
      res  = wide[DATA_W-1:0];
      cout = wide[DATA_W];
      half = low[NIB];
   end

   // R4: the nibble carry must never be set on an add of two zero low nibbles without carry-in
   always_comb begin
      if (!sub && !cin && a[NIB-1:0] == '0 && b[NIB-1:0] == '0)
         nibble_zero_chk: assert (!half);
   end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cy_in,
   output logic [DATA_W-1:0] res,
   output logic              cy_out
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      res    = a;
      cy_out = cy_in;
      case (op)
         OP_AND: res = a & b;
         OP_XOR: res = a ^ b;
         OP_OR:  res = a | b;
         OP_CMA: res = ~a;
         OP_CMC: cy_out = ~cy_in;
         OP_STC: cy_out = 1'b1;
         OP_RLC: begin
            res    = {a[MSB-1:0], a[MSB]};
            cy_out = a[MSB];
         end
         OP_RRC: begin
            res    = {a[0], a[MSB:1]};
            cy_out = a[0];
         end
         OP_RAL: begin
            res    = {a[MSB-1:0], cy_in};
            cy_out = a[MSB];
         end
         OP_RAR: begin
            res    = {cy_in, a[MSB:1]};
            cy_out = a[0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_szp.sv
module acc_alu_szp #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] val,
   output logic              s,
   output logic              z,
   output logic              p
);
   assign s = val[DATA_W-1];
   assign z = (val == '0);
   assign p = ~^val;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_code,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [DATA_W-1:0] acc_out,
   output logic [FLAG_W-1:0] flags_out
);
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("acc_alu: DATA_W must be even and at least 4");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(op_code);

   logic              cy_cur;
   logic [FLAG_W-1:0] flags_norm;
   assign cy_cur     = flags_in[FB_CY];
   assign flags_norm = pack_flags(flags_in[FB_S], flags_in[FB_Z], flags_in[FB_AC],
                                  flags_in[FB_P], flags_in[FB_CY]);

   logic              is_step, is_sub, is_logic, ar_cin;
   logic [DATA_W-1:0] ar_b;
   assign is_step  = (op == OP_INC) || (op == OP_DEC);
   assign is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) || (op == OP_DEC);
   assign is_logic = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
   assign ar_cin   = ((op == OP_ADC) || (op == OP_SBB)) ? cy_cur : 1'b0;
   assign ar_b     = is_step ? ONE : operand;

   logic [DATA_W-1:0] ar_res, lg_res, szp_src;
   logic              ar_cout, ar_half, lg_cy;
   logic              f_s, f_z, f_p;

   acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
      .a(acc_in), .b(ar_b), .sub(is_sub), .cin(ar_cin),
      .res(ar_res), .cout(ar_cout), .half(ar_half)
   );

   acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .op(op), .a(acc_in), .b(operand), .cy_in(cy_cur),
      .res(lg_res), .cy_out(lg_cy)
   );

   assign szp_src = is_logic ? lg_res : ar_res;

   acc_alu_szp #(.DATA_W(DATA_W)) u_szp (
      .val(szp_src), .s(f_s), .z(f_z), .p(f_p)
   );

   logic [DATA_W-1:0] acc_nxt;
   logic [FLAG_W-1:0] flags_nxt;

   always_comb begin
      acc_nxt   = acc_in;
      flags_nxt = flags_norm;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            acc_nxt   = ar_res;
            flags_nxt = pack_flags(f_s, f_z, ar_half, f_p, ar_cout);
         end
         OP_CMP:
            flags_nxt = pack_flags(f_s, f_z, ar_half, f_p, ar_cout);
         OP_INC, OP_DEC: begin
            acc_nxt   = ar_res;
            flags_nxt = pack_flags(f_s, f_z, ar_half, f_p, cy_cur);
         end
         OP_AND, OP_XOR, OP_OR: begin
            acc_nxt   = lg_res;
            flags_nxt = pack_flags(f_s, f_z, 1'b0, f_p, 1'b0);
         end
         OP_CMA, OP_CMC, OP_STC, OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
            acc_nxt            = lg_res;
            flags_nxt[FB_CY]   = lg_cy;
         end
         default: ;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_out   <= '0;
               flags_out <= FLAG_RESET;
            end else begin
               acc_out   <= acc_nxt;
               flags_out <= flags_nxt;
            end
         end

         // R7
         cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_CMP) |=> (acc_out == $past(acc_in)));

         // R8
         step_keeps_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((op == OP_INC) || (op == OP_DEC)) |=> (flags_out[FB_CY] == $past(flags_in[FB_CY])));

         // R5
         zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code <= 5'd6 || op == OP_INC || op == OP_DEC)
               |=> (flags_out[FB_Z] == (acc_out == '0)));

         // R5
         parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code <= 5'd6 || op == OP_INC || op == OP_DEC)
               |=> (flags_out[FB_P] == ~^acc_out));

         // R10
         rotate_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code >= 5'd13 && op_code <= 5'd16)
               |=> (flags_out[FLAG_W-1:FB_P] ==
                    $past({flags_in[FB_S], flags_in[FB_Z], 1'b0, flags_in[FB_AC], 1'b0, flags_in[FB_P]})));

         // R9
         cmc_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_CMC) |=> (flags_out[FB_CY] != $past(flags_in[FB_CY])));
      end else begin : g_comb
         assign acc_out   = acc_nxt;
         assign flags_out = flags_nxt;
      end
   endgenerate
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/100ps
module acc_alu_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_code = '0;
   logic [7:0] operand = '0;
   logic [7:0] acc_in = '0;
   logic [7:0] flags_in = '0;
   logic [7:0] acc_out;
   logic [7:0] flags_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   acc_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .operand(operand),
      .acc_in(acc_in), .flags_in(flags_in), .acc_out(acc_out), .flags_out(flags_out)
   );

   function automatic int ones(input int v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += (v >> i) & 1;
      return n;
   endfunction

   // behavioural model: returns {acc, flags}
   function automatic logic [15:0] model(input int op, input int a, input int b, input int f);
      int s, z, h, p, c, r, t, cin, szp_v;
      bit upd;
      s = (f >> 7) & 1; z = (f >> 6) & 1; h = (f >> 4) & 1;
      p = (f >> 2) & 1; c = f & 1;
      r = a; upd = 0; szp_v = 0;
      case (op)
         0, 1: begin
            cin = (op == 1) ? c : 0;
            t = a + b + cin; r = t % 256;
            c = (t > 255); h = ((a % 16) + (b % 16) + cin) > 15;
            szp_v = r; upd = 1;
         end
         2, 3, 7: begin
            cin = (op == 3) ? c : 0;
            t = a - b - cin;
            c = (t < 0); h = ((a % 16) - (b % 16) - cin) < 0;
            szp_v = (t + 512) % 256; upd = 1;
            if (op != 7) r = szp_v;
         end
         4, 5, 6: begin
            if (op == 4) r = a & b; else if (op == 5) r = a ^ b; else r = a | b;
            c = 0; h = 0; szp_v = r; upd = 1;
         end
         8: begin h = (a % 16) == 15; r = (a + 1) % 256; szp_v = r; upd = 1; end
         9: begin h = (a % 16) == 0; r = (a + 255) % 256; szp_v = r; upd = 1; end
         10: r = 255 - a;
         11: c = 1 - c;
         12: c = 1;
         13: begin c = (a >> 7) & 1; r = ((a * 2) % 256) + c; end
         14: begin c = a & 1; r = (a / 2) + c * 128; end
         15: begin r = ((a * 2) % 256) + c; c = (a >> 7) & 1; end
         16: begin r = (a / 2) + c * 128; c = a & 1; end
         default: ;
      endcase
      if (upd) begin
         s = (szp_v >> 7) & 1; z = (szp_v == 0);
         p = (ones(szp_v) % 2) == 0;
      end
      return {r[7:0], s[0], z[0], 1'b0, h[0], 1'b0, p[0], 1'b1, c[0]};
   endfunction

   function automatic string tag(input int op);
      case (op)
         0, 1:    return "R2 R4 R5 R12";
         2, 3:    return "R3 R4 R5 R12";
         4, 5, 6: return "R6 R5 R12";
         7:       return "R7 R4 R5";
         8, 9:    return "R8 R4 R5";
         10, 11, 12: return "R9";
         13, 14:  return "R11";
         15, 16:  return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic apply(input int op, input int a, input int b, input int f, input string why);
      logic [15:0] exp;
      op_code = op[4:0]; acc_in = a[7:0]; operand = b[7:0]; flags_in = f[7:0];
      exp = model(op, a, b, f);
      @(negedge clk);
      checks++;
      if ({acc_out, flags_out} !== exp) begin
         errors++;
         $display("FAIL %s op=%0d a=%h b=%h f=%h: actual acc=%h flags=%h expected acc=%h flags=%h",
                  why, op, a[7:0], b[7:0], f[7:0], acc_out, flags_out, exp[15:8], exp[7:0]);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int pats[6] = '{8'h00, 8'hFF, 8'h0F, 8'h80, 8'h7F, 8'h01};
      int fls[2]  = '{8'h00, 8'hFF};
      op_code = 5'd0; acc_in = 8'h5A; operand = 8'hA5; flags_in = 8'hFF;
      @(negedge clk); @(negedge clk);
      // R1: held in reset
      checks++;
      if (acc_out !== 8'h00 || flags_out !== 8'h02) begin
         errors++;
         $display("FAIL R1 reset: actual acc=%h flags=%h expected acc=00 flags=02", acc_out, flags_out);
      end
      rst_n = 1'b1;
      // R2: worked example 88h + 99h
      apply(0, 8'h88, 8'h99, 8'h00, "R2 example");
      checks++;
      if (acc_out !== 8'h21 || flags_out !== 8'h17) begin
         errors++;
         $display("FAIL R2 literal: actual acc=%h flags=%h expected acc=21 flags=17", acc_out, flags_out);
      end
      // R3 R4: borrow and nibble borrow cases
      apply(3, 8'h10, 8'h0F, 8'h01, "R3 sbb borrow");
      apply(2, 8'h00, 8'h01, 8'h00, "R3 negative");
      // R7: compare equal leaves A
      apply(7, 8'h42, 8'h42, 8'h00, "R7 cmp equal");
      // R10 R11: rotate edges
      apply(15, 8'h80, 8'h00, 8'h00, "R10 ral");
      apply(16, 8'h01, 8'h00, 8'h01, "R10 rar");
      apply(13, 8'h81, 8'h00, 8'h00, "R11 rlc");
      apply(14, 8'h02, 8'h00, 8'h01, "R11 rrc");
      // R12: undefined code with junk filler bits
      apply(31, 8'h3C, 8'h00, 8'h28, "R12 undefined");
      // directed sweep
      for (int op = 0; op <= 18; op++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               for (int k = 0; k < 2; k++)
                  apply(op, pats[i], pats[j], fls[k], tag(op));
      // random vectors
      for (int n = 0; n < 4000; n++) begin
         int op = $urandom_range(0, 31);
         apply(op, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255), tag(op));
      end
      // R1: reset again returns to reset values
      rst_n = 1'b0;
      #1;
      checks++;
      if (acc_out !== 8'h00 || flags_out !== 8'h02) begin
         errors++;
         $display("FAIL R1 re-reset: actual acc=%h flags=%h expected acc=00 flags=02", acc_out, flags_out);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule